// File: doc/BRIEF.md
# Clock-Gating Power-Mode Controller

This block sequences a processor core between four power modes (Run, Idle, Standby, Sleep) and turns the chosen mode into control levels: a root clock enable, a PLL-stop request, a body-bias request and a state-retention flag. Below the root enable sits a three-tier gating tree. The root enable qualifies a vector of global-domain enables. Each global enable then qualifies a vector of per-buffer local enables. Every local clock buffer receives a registered pulse enable that is high only when all three tiers agree.

Software or a power manager posts a mode request with a one-cycle valid strobe. A request that arrives while a transition is under way is held (the latest one wins) and is served once the controller settles. Leaving Standby lowers body bias first and then restarts the PLL. Leaving Sleep restarts the PLL and then issues a one-cycle reset request, because nothing was retained. Both wake paths wait a programmable lock count before the root clock comes back. The mapping of each local buffer to its parent domain is a parameter table.

States, all named: RUN, IDLE, GATE (root gated before the PLL stops), STBY, SLEEP, BIAS_OFF (bias lowered, PLL still stopped), PLL_LOCK (PLL running, counting lock cycles) and WAKE_RST (reset pulse after Sleep). Transitions:
- RUN to IDLE; RUN to GATE; GATE to STBY or SLEEP.
- IDLE to RUN.
- STBY to BIAS_OFF to PLL_LOCK.
- SLEEP to PLL_LOCK.
- PLL_LOCK to RUN (coming from Standby) or to WAKE_RST (coming from Sleep).
- WAKE_RST to RUN.

Top module: `clkgate_pwr_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the block is in Run: root_clk_en=1, pll_stop=0, bias_req=0, retain=1, busy=0, rst_req=0, and every buf_pulse_en bit is 0.
- R2: buf_pulse_en[i] equals, one clock later, root_clk_en AND glb_en[d] AND lcl_en[i]. Here d is the field BUF_MAP[DOM_W*i +: DOM_W]. The default table puts buffer i in domain i/2.
- R3: A valid Idle request in Run gives, after the next edge, root_clk_en=0, pll_stop=0, bias_req=0, retain=1, busy=0. A valid Run request in Idle restores the Run levels after the next edge.
- R4: A Standby request in Run first gives one gating cycle (root_clk_en=0, busy=1, pll_stop=0). It then gives pll_stop=1, bias_req=1, retain=1, busy=0. The PLL never stops while the root clock is still enabled.
- R5: A wake from Standby first gives one cycle with bias_req=0, pll_stop=1, busy=1. It then gives lock_cycles+1 cycles with pll_stop=0, busy=1, retain=1, and then Run. The PLL restarts only after body bias has been low for a cycle.
- R6: A Sleep request in Run gives one gating cycle, then pll_stop=1, bias_req=0, retain=0, busy=0.
- R7: A wake from Sleep gives lock_cycles+1 cycles with pll_stop=0, busy=1, retain=0. It then gives one cycle with rst_req=1, and then Run with retain=1.
- R8: A request posted while busy=1 is held and served once the block settles; a later request replaces an earlier held one. A request for the current mode leaves all outputs unchanged.
- R9: A request in Idle, Standby or Sleep for a different low-power mode first completes the full wake to Run, then enters the requested mode from Run.
- R10: mode_req is sampled only when mode_req_vld=1, with the encoding 0=Run, 1=Idle, 2=Standby, 3=Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_vld | input | 1 | Strobe qualifying mode_req |
| mode_req | input | 2 | Requested mode (0 Run, 1 Idle, 2 Standby, 3 Sleep) |
| lock_cycles | input | LOCK_W | PLL lock wait, loaded when a wake enters PLL_LOCK |
| glb_en | input | N_DOM | Global clock-domain enables |
| lcl_en | input | N_BUF | Local clock-buffer enables |
| root_clk_en | output | 1 | Root clock enable |
| pll_stop | output | 1 | Request to halt the PLL |
| bias_req | output | 1 | Reverse body-bias request |
| retain | output | 1 | Architectural state is being retained |
| busy | output | 1 | A mode transition is in progress |
| rst_req | output | 1 | One-cycle reset request after a Sleep wake |
| buf_pulse_en | output | N_BUF | Registered pulse enable per local buffer |

## Verification
The assertions assume the following about the inputs: every BUF_MAP field names an existing domain; rst_n is the only asynchronous input; and the external PLL and bias circuits follow pll_stop and bias_req, so only the ordering of those requests needs checking. The stimulus changes every input half a cycle away from the active edge. It holds lock_cycles constant through each wake so that the expected lock window is known, and it always writes mode_req with one of the four legal codes.

// File: rtl/cgpm_pkg.sv
package cgpm_pkg;

    typedef enum logic [1:0] {
        M_RUN   = 2'd0,
        M_IDLE  = 2'd1,
        M_STBY  = 2'd2,
        M_SLEEP = 2'd3
    } pm_mode_e;

    typedef enum logic [2:0] {
        S_RUN,
        S_IDLE,
        S_GATE,
        S_STBY,
        S_SLEEP,
        S_BIAS_OFF,
        S_PLL_LOCK,
        S_WAKE_RST
    } pm_state_e;

    typedef struct packed {
        logic root_en;
        logic pll_stop;
        logic bias_req;
        logic retain;
        logic busy;
        logic rst_req;
    } pm_ctl_t;

endpackage

// File: rtl/cgpm_fsm.sv
module cgpm_fsm
    import cgpm_pkg::*;
#(
    parameter int LOCK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req_vld,
    input  logic [1:0]        mode_req,
    input  logic [LOCK_W-1:0] lock_cycles,
    output pm_ctl_t           ctl
);

    pm_state_e         st, st_nxt;
    pm_mode_e          tgt_q;
    pm_mode_e          pend_mode_q;
    logic              pend_vld_q;
    logic              from_sleep_q;
    logic [LOCK_W-1:0] lock_cnt_q;

    // Effective request: a fresh strobe overrides a held one.
    logic     req_v;
    pm_mode_e req_m;
    logic     consume;

    assign req_v = mode_req_vld | pend_vld_q;
    assign req_m = mode_req_vld ? pm_mode_e'(mode_req) : pend_mode_q;

    // Next-state logic
    always_comb begin
        st_nxt  = st;
        consume = 1'b0;
        unique case (st)
            S_RUN: begin
                if (req_v) begin
                    consume = 1'b1;
                    case (req_m)
                        M_IDLE:  st_nxt = S_IDLE;
                        M_STBY:  st_nxt = S_GATE;
                        M_SLEEP: st_nxt = S_GATE;
                        default: st_nxt = S_RUN;
                    endcase
                end
            end
            S_IDLE: begin
                if (req_v) begin
                    consume = (req_m == M_RUN) || (req_m == M_IDLE);
                    if (req_m != M_IDLE) st_nxt = S_RUN;
                end
            end
            S_GATE:
                st_nxt = (tgt_q == M_SLEEP) ? S_SLEEP : S_STBY;
            S_STBY: begin
                if (req_v) begin
                    consume = (req_m == M_RUN) || (req_m == M_STBY);
                    if (req_m != M_STBY) st_nxt = S_BIAS_OFF;
                end
            end
            S_SLEEP: begin
                if (req_v) begin
                    consume = (req_m == M_RUN) || (req_m == M_SLEEP);
                    if (req_m != M_SLEEP) st_nxt = S_PLL_LOCK;
                end
            end
            S_BIAS_OFF:
                st_nxt = S_PLL_LOCK;
            S_PLL_LOCK: begin
                if (lock_cnt_q == '0)
                    st_nxt = from_sleep_q ? S_WAKE_RST : S_RUN;
            end
            S_WAKE_RST:
                st_nxt = S_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_RUN;
        else        st <= st_nxt;
    end

    // Transition bookkeeping: target, held request, wake origin, lock count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q        <= M_RUN;
            pend_mode_q  <= M_RUN;
            pend_vld_q   <= 1'b0;
            from_sleep_q <= 1'b0;
            lock_cnt_q   <= '0;
        end else begin
            if (st == S_RUN && consume)
                tgt_q <= req_m;

            if (consume) begin
                pend_vld_q <= 1'b0;
            end else if (req_v) begin
                pend_vld_q  <= 1'b1;
                pend_mode_q <= req_m;
            end

            if (st == S_SLEEP && st_nxt == S_PLL_LOCK)
                from_sleep_q <= 1'b1;
            else if (st_nxt == S_RUN)
                from_sleep_q <= 1'b0;

            if (st != S_PLL_LOCK && st_nxt == S_PLL_LOCK)
                lock_cnt_q <= lock_cycles;
            else if (st == S_PLL_LOCK && lock_cnt_q != '0)
                lock_cnt_q <= lock_cnt_q - 1'b1;
        end
    end

    // Output decode
    always_comb begin
        ctl = '0;
        unique case (st)
            S_RUN:      begin ctl.root_en = 1'b1; ctl.retain = 1'b1; end
            S_IDLE:     begin ctl.retain = 1'b1; end
            S_GATE:     begin ctl.retain = 1'b1; ctl.busy = 1'b1; end
            S_STBY:     begin ctl.pll_stop = 1'b1; ctl.bias_req = 1'b1; ctl.retain = 1'b1; end
            S_SLEEP:    begin ctl.pll_stop = 1'b1; end
            S_BIAS_OFF: begin ctl.pll_stop = 1'b1; ctl.retain = 1'b1; ctl.busy = 1'b1; end
            S_PLL_LOCK: begin ctl.retain = !from_sleep_q; ctl.busy = 1'b1; end
            S_WAKE_RST: begin ctl.busy = 1'b1; ctl.rst_req = 1'b1; end
        endcase
    end

endmodule

// File: rtl/cgpm_gate_tree.sv
module cgpm_gate_tree #(
    parameter int                     N_DOM   = 4,
    parameter int                     N_BUF   = 8,
    parameter int                     DOM_W   = 2,
    parameter logic [N_BUF*DOM_W-1:0] BUF_MAP = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             root_en,
    input  logic [N_DOM-1:0] glb_en,
    input  logic [N_BUF-1:0] lcl_en,
    output logic [N_BUF-1:0] buf_en
);

    for (genvar i = 0; i < N_BUF; i++) begin : g_buf
        localparam int PARENT = int'(BUF_MAP[i*DOM_W +: DOM_W]);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) buf_en[i] <= 1'b0;
            else        buf_en[i] <= root_en & glb_en[PARENT] & lcl_en[i];
        end
    end

endmodule

// File: rtl/clkgate_pwr_ctrl.sv
module clkgate_pwr_ctrl
    import cgpm_pkg::*;
#(
    parameter int                     N_DOM   = 4,
    parameter int                     N_BUF   = 8,
    parameter int                     DOM_W   = (N_DOM > 1) ? $clog2(N_DOM) : 1,
    parameter int                     LOCK_W  = 8,
    parameter logic [N_BUF*DOM_W-1:0] BUF_MAP = 16'hFA50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req_vld,
    input  logic [1:0]        mode_req,
    input  logic [LOCK_W-1:0] lock_cycles,
    input  logic [N_DOM-1:0]  glb_en,
    input  logic [N_BUF-1:0]  lcl_en,
    output logic              root_clk_en,
    output logic              pll_stop,
    output logic              bias_req,
    output logic              retain,
    output logic              busy,
    output logic              rst_req,
    output logic [N_BUF-1:0]  buf_pulse_en
);

    pm_ctl_t ctl;

    cgpm_fsm #(.LOCK_W(LOCK_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_req_vld (mode_req_vld),
        .mode_req     (mode_req),
        .lock_cycles  (lock_cycles),
        .ctl          (ctl)
    );

    cgpm_gate_tree #(
        .N_DOM   (N_DOM),
        .N_BUF   (N_BUF),
        .DOM_W   (DOM_W),
        .BUF_MAP (BUF_MAP)
    ) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .root_en (ctl.root_en),
        .glb_en  (glb_en),
        .lcl_en  (lcl_en),
        .buf_en  (buf_pulse_en)
    );

    assign root_clk_en = ctl.root_en;
    assign pll_stop    = ctl.pll_stop;
    assign bias_req    = ctl.bias_req;
    assign retain      = ctl.retain;
    assign busy        = ctl.busy;
    assign rst_req     = ctl.rst_req;

endmodule

// File: rtl/cgpm_chk.sv
module cgpm_chk #(
    parameter int N_BUF = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             root_clk_en,
    input logic             pll_stop,
    input logic             bias_req,
    input logic             retain,
    input logic             busy,
    input logic             rst_req,
    input logic [N_BUF-1:0] buf_pulse_en
);

    // R4: body bias only while the PLL is stopped and the root clock is gated
    p_bias_needs_pll_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bias_req |-> (pll_stop && !root_clk_en));

    // R4: the PLL stops only after the root clock was already gated
    p_pll_stop_after_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_stop) |-> (!root_clk_en && $past(!root_clk_en)));

    // R5: the PLL restarts only once bias was low in the cycle before
    p_pll_restart_after_bias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_stop) |-> (!bias_req && $past(!bias_req)));

    // R7: the reset request is a single busy, non-retaining cycle followed by Run
    p_rst_req_no_retain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (!retain && busy));

    p_rst_req_then_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (root_clk_en && retain && !busy && !rst_req));

    // R2: no local pulse enable without the root enable one cycle earlier
    p_buf_needs_root_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|buf_pulse_en) |-> $past(root_clk_en));

    // R3: the root clock runs only when settled with the PLL running
    p_root_only_settled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        root_clk_en |-> (!busy && !pll_stop && retain));

endmodule

bind clkgate_pwr_ctrl cgpm_chk #(.N_BUF(N_BUF)) u_cgpm_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .root_clk_en  (root_clk_en),
    .pll_stop     (pll_stop),
    .bias_req     (bias_req),
    .retain       (retain),
    .busy         (busy),
    .rst_req      (rst_req),
    .buf_pulse_en (buf_pulse_en)
);

// File: tb/clkgate_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module clkgate_pwr_ctrl_bench;

    localparam int NB = 8;
    localparam int ND = 4;

    // Expected control flags {root, pll_stop, bias, retain, busy, rst_req}
    localparam logic [5:0] F_RUN    = 6'b100100;
    localparam logic [5:0] F_IDLE   = 6'b000100;
    localparam logic [5:0] F_GATE   = 6'b000110;
    localparam logic [5:0] F_STBY   = 6'b011100;
    localparam logic [5:0] F_SLEEP  = 6'b010000;
    localparam logic [5:0] F_BOFF   = 6'b010110;
    localparam logic [5:0] F_LOCK_S = 6'b000110;
    localparam logic [5:0] F_LOCK_Z = 6'b000010;
    localparam logic [5:0] F_WRST   = 6'b000011;

    localparam logic [1:0] Q_RUN = 2'd0, Q_IDLE = 2'd1, Q_STBY = 2'd2, Q_SLEEP = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_req_vld = 1'b0;
    logic [1:0]    mode_req = 2'd0;
    logic [7:0]    lock_cycles = 8'd3;
    logic [ND-1:0] glb_en = '1;
    logic [NB-1:0] lcl_en = '1;
    logic          root_clk_en, pll_stop, bias_req, retain, busy, rst_req;
    logic [NB-1:0] buf_pulse_en;

    always #4 clk = ~clk;

    clkgate_pwr_ctrl u_clkgate_pwr_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_req_vld (mode_req_vld),
        .mode_req     (mode_req),
        .lock_cycles  (lock_cycles),
        .glb_en       (glb_en),
        .lcl_en       (lcl_en),
        .root_clk_en  (root_clk_en),
        .pll_stop     (pll_stop),
        .bias_req     (bias_req),
        .retain       (retain),
        .busy         (busy),
        .rst_req      (rst_req),
        .buf_pulse_en (buf_pulse_en)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    logic  root_now = 1'b1;
    logic [NB+5:0] exp_q[$];
    string         tag_q[$];

    function automatic logic [NB+5:0] observed();
        return {root_clk_en, pll_stop, bias_req, retain, busy, rst_req, buf_pulse_en};
    endfunction

    // Driver: one call per clock; pushes what must appear after the next edge
    task automatic cyc(input logic v, input logic [1:0] m, input logic [5:0] f,
                       input logic [ND-1:0] g, input logic [NB-1:0] l, input string tag);
        logic [NB-1:0] bexp;
        @(negedge clk);
        mode_req_vld = v;
        mode_req     = m;
        glb_en       = g;
        lcl_en       = l;
        for (int i = 0; i < NB; i++) bexp[i] = root_now & g[i/2] & l[i];
        exp_q.push_back({f, bexp});
        tag_q.push_back(tag);
        root_now = f[5];
    endtask

    task automatic idle_cyc(input logic [5:0] f, input string tag);
        cyc(1'b0, Q_RUN, f, glb_en, lcl_en, tag);
    endtask

    // Monitor: samples 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [NB+5:0] e;
            string         t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (observed() !== e) begin
                n_bad++;
                $display("FAIL %s: got %b expected %b", t, observed(), e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        n_cmp++;
        if (observed() !== {F_RUN, 8'h00}) begin
            n_bad++;
            $display("FAIL R1: got %b expected %b", observed(), {F_RUN, 8'h00});
        end
        rst_n = 1'b1;

        // R1 / R2: Run with several enable patterns (buffer i -> domain i/2)
        cyc(0, Q_RUN, F_RUN, 4'hF, 8'hFF, "R1");
        cyc(0, Q_RUN, F_RUN, 4'h5, 8'hFF, "R2");
        cyc(0, Q_RUN, F_RUN, 4'hF, 8'hA5, "R2");
        cyc(0, Q_RUN, F_RUN, 4'hA, 8'h3C, "R2");
        cyc(0, Q_RUN, F_RUN, 4'h0, 8'hFF, "R2");
        cyc(0, Q_RUN, F_RUN, 4'hF, 8'hFF, "R2");

        // R8 / R10: same-mode request changes nothing
        cyc(1, Q_RUN, F_RUN, 4'hF, 8'hFF, "R8");
        cyc(0, Q_RUN, F_RUN, 4'hF, 8'hFF, "R8");

        // R3: Idle and back
        cyc(1, Q_IDLE, F_IDLE, 4'hF, 8'hFF, "R3");
        cyc(0, Q_RUN, F_IDLE, 4'hF, 8'hFF, "R3");
        cyc(0, Q_RUN, F_IDLE, 4'hF, 8'hFF, "R2");
        cyc(1, Q_IDLE, F_IDLE, 4'hF, 8'hFF, "R8");
        cyc(1, Q_RUN, F_RUN, 4'hF, 8'hFF, "R3");
        cyc(0, Q_RUN, F_RUN, 4'hC, 8'hF0, "R2");

        // R4 / R5: Standby entry, same-mode request, exit with lock 3
        cyc(1, Q_STBY, F_GATE, 4'hF, 8'hFF, "R4");
        idle_cyc(F_STBY, "R4");
        cyc(1, Q_STBY, F_STBY, 4'hF, 8'hFF, "R8");
        cyc(1, Q_RUN, F_BOFF, 4'hF, 8'hFF, "R5");
        for (int k = 0; k < 4; k++) idle_cyc(F_LOCK_S, "R5");
        idle_cyc(F_RUN, "R5");
        idle_cyc(F_RUN, "R5");

        // R8 / R9: Sleep request posted during the gating cycle of a Standby entry
        cyc(1, Q_STBY, F_GATE, 4'hF, 8'hFF, "R4");
        cyc(1, Q_SLEEP, F_STBY, 4'hF, 8'hFF, "R8");
        idle_cyc(F_BOFF, "R9");
        for (int k = 0; k < 4; k++) idle_cyc(F_LOCK_S, "R9");
        idle_cyc(F_RUN, "R9");
        idle_cyc(F_GATE, "R8");
        idle_cyc(F_SLEEP, "R6");
        idle_cyc(F_SLEEP, "R6");

        // R7: Sleep wake with lock 3
        cyc(1, Q_RUN, F_LOCK_Z, 4'hF, 8'hFF, "R7");
        for (int k = 0; k < 3; k++) idle_cyc(F_LOCK_Z, "R7");
        idle_cyc(F_WRST, "R7");
        idle_cyc(F_RUN, "R7");
        idle_cyc(F_RUN, "R2");

        // R9: Idle to Standby passes through Run
        cyc(1, Q_IDLE, F_IDLE, 4'hF, 8'hFF, "R3");
        cyc(1, Q_STBY, F_RUN, 4'hF, 8'hFF, "R9");
        idle_cyc(F_GATE, "R9");
        idle_cyc(F_STBY, "R9");

        // R8: later held request replaces an earlier one during the wake
        cyc(1, Q_RUN, F_BOFF, 4'hF, 8'hFF, "R5");
        cyc(1, Q_SLEEP, F_LOCK_S, 4'hF, 8'hFF, "R8");
        cyc(1, Q_IDLE, F_LOCK_S, 4'hF, 8'hFF, "R8");
        idle_cyc(F_LOCK_S, "R5");
        idle_cyc(F_LOCK_S, "R5");
        idle_cyc(F_RUN, "R5");
        idle_cyc(F_IDLE, "R8");
        cyc(1, Q_RUN, F_RUN, 4'hF, 8'hFF, "R3");

        // R6 / R7: Sleep with lock count 0 (boundary)
        lock_cycles = 8'd0;
        cyc(1, Q_SLEEP, F_GATE, 4'hF, 8'hFF, "R6");
        idle_cyc(F_SLEEP, "R6");
        cyc(1, Q_SLEEP, F_SLEEP, 4'hF, 8'hFF, "R8");
        cyc(1, Q_RUN, F_LOCK_Z, 4'hF, 8'hFF, "R7");
        idle_cyc(F_WRST, "R7");
        idle_cyc(F_RUN, "R7");
        cyc(0, Q_RUN, F_RUN, 4'h3, 8'h0F, "R2");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule